// File: doc/BRIEF.md
# Multi-Output Video Sync Generator

This block produces horizontal and vertical sync timing for a raster display from a pixel-clock sample counter and a line counter. It drives four independent hsync/vsync pairs. Each pair has its own edge positions, so several display interfaces can take syncs from one timebase, each shifted by the delay its own pipeline needs. Any edge may sit anywhere in the line or the frame, and a pulse may wrap across the line boundary or the frame boundary.

Software programs the block through a single-cycle write port. The port sets the line length, the frame height, the run mode, and the edge positions of each channel. Every write lands in a pending copy. The running copy takes the pending values only at a frame start, so a sync pulse is never cut short by a write. In slave mode, an external frame-sync input restarts the counters. In master mode the counters run free and the external input has no effect.

Top module: `video_sync_gen`

## Requirements
- R1: A synchronous reset (`rst` high) puts the counters at the frame start (sample 0, line 1) and clears every pending and running register to zero. With all-zero registers, every hsync and vsync output is low, both during reset and after it.
- R2: The sample counter counts 0, 1, … up to one below the line length and then returns to 0. The line length is register address 1, bits 15:0. A length of 0 or 1 makes every cycle the end of a line.
- R3: Lines are numbered from 1. The line counter advances when the sample counter returns to 0. After the line equal to the frame height (address 2, bits 15:0), it returns to line 1. A height of 0 makes every line the last line.
- R4: Channel c (c = 0 to 3) has its registers at base 8·(c+1). Its horizontal register at base+0 holds the stop sample in bits 31:16 and the start sample in bits 15:0. When start ≤ stop, hsync is high for start ≤ sample < stop. When start equals stop, hsync never goes high.
- R5: When the stop sample is below the start sample, hsync wraps: it is high for sample ≥ start or sample < stop.
- R6: Vsync uses (line, sample) points compared line-first. The rise point takes its line from base+1 bits 15:0 and its sample from base+3 bits 15:0. The fall point takes its line from base+1 bits 31:16 and its sample from base+3 bits 31:16. Vsync is high from the rise point (inclusive) up to the fall point (exclusive). It never goes high when the two points are equal. When the fall point is before the rise point, the pulse wraps across the frame end, for example rising on the last line and falling a few lines into the next frame.
- R7: Writes update pending registers only. The running registers take the pending values at the next frame start, which is either a natural wrap from the last sample of the last line or a slave restart. Until then the outputs follow the old values.
- R8: Address 0 bit 0 selects the run mode: 1 is slave. In slave mode, `ext_sync` high at a clock edge puts the counters at sample 0, line 1 after that edge.
- R9: In master mode (address 0 bit 0 = 0), `ext_sync` has no effect on the counters or the outputs.
- R10: Writes to the bottom-field addresses (base+2 and base+4) and to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W (6) | Register address |
| wr_data | input | 32 | Register write data |
| ext_sync | input | 1 | External frame restart, used in slave mode |
| hsync_o | output | NUM_CH (4) | Horizontal sync per channel, active high |
| vsync_o | output | NUM_CH (4) | Vertical sync per channel, active high |

## Verification
The counter bound checks assume that the running line length and frame height change only at a frame start, when the counters are already at sample 0, line 1. The stimulus therefore reaches the block only through the write port and never forces a load at any other time. The assertions also assume `wr_addr`, `wr_en` and `ext_sync` are known values at every clock edge. The bench drives them only at the falling edge and holds them stable across the rising edge. Channel edge positions may lie outside the programmed line or frame; such a pulse simply never sees that edge. The stimulus keeps most rows inside the 10-sample, 6-line frame, so that the per-frame pulse counts stay meaningful.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   // Field width of every packed 16/16 register half
   localparam int FLD_W    = 16;
   localparam int REG_W    = 2 * FLD_W;
   // Channel register groups are spaced 2**CH_SHIFT apart, group 0 is global
   localparam int CH_SHIFT = 3;

   // Global register addresses
   localparam int ADR_MODE = 0;
   localparam int ADR_HTOT = 1;
   localparam int ADR_VTOT = 2;

   // Per-channel sub-offsets that hold state (others are accepted and dropped)
   localparam int OFS_HZ    = 0;
   localparam int OFS_VLINE = 1;
   localparam int OFS_VSMP  = 3;

   typedef logic [FLD_W-1:0] fld_t;

   typedef struct packed {
      fld_t h_stop;
      fld_t h_start;
      fld_t vl_fall;
      fld_t vl_rise;
      fld_t vs_fall;
      fld_t vs_rise;
   } ch_cfg_t;
endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
   import vsg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 6
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [REG_W-1:0]         wr_data,
   input  logic                     load,
   output logic                     slave_q,
   output fld_t                     htot_q,
   output fld_t                     vtot_q,
   output ch_cfg_t [NUM_CH-1:0]     cfg_q
);
   localparam int GRP_W = ADDR_W - CH_SHIFT;

   logic slave_s;
   fld_t htot_s, vtot_s;

   // Global registers: pending copy on write, running copy on frame start
   always_ff @(posedge clk) begin
      if (rst) begin
         slave_s <= 1'b0;
         htot_s  <= '0;
         vtot_s  <= '0;
         slave_q <= 1'b0;
         htot_q  <= '0;
         vtot_q  <= '0;
      end else begin
         if (load) begin
            slave_q <= slave_s;
            htot_q  <= htot_s;
            vtot_q  <= vtot_s;
         end
         if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_MODE)) slave_s <= wr_data[0];
            if (wr_addr == ADDR_W'(ADR_HTOT)) htot_s  <= wr_data[FLD_W-1:0];
            if (wr_addr == ADDR_W'(ADR_VTOT)) vtot_s  <= wr_data[FLD_W-1:0];
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ch_cfg_t sh, act;
      logic    hit;
      assign hit = wr_en && (wr_addr[ADDR_W-1:CH_SHIFT] == GRP_W'(c + 1));

      always_ff @(posedge clk) begin
         if (rst) begin
            sh  <= '0;
            act <= '0;
         end else begin
            if (load) act <= sh;
            if (hit) begin
               case (wr_addr[CH_SHIFT-1:0])
                  CH_SHIFT'(OFS_HZ):    {sh.h_stop,  sh.h_start} <= wr_data;
                  CH_SHIFT'(OFS_VLINE): {sh.vl_fall, sh.vl_rise} <= wr_data;
                  CH_SHIFT'(OFS_VSMP):  {sh.vs_fall, sh.vs_rise} <= wr_data;
                  default: ;  // bottom-field copies and spare offsets
               endcase
            end
         end
      end
      assign cfg_q[c] = act;
   end

   // R7: the running set moves only on a frame start
   a_r7_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(cfg_q) && $stable(htot_q) && $stable(vtot_q) && $stable(slave_q)));
endmodule

// File: rtl/vsg_counter.sv
module vsg_counter
   import vsg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  fld_t htot,
   input  fld_t vtot,
   input  logic restart,
   output fld_t smp,
   output fld_t line,
   output logic frame_end
);
   logic [FLD_W:0] smp_inc;
   logic           line_end;

   assign smp_inc   = {1'b0, smp} + 1'b1;
   assign line_end  = smp_inc >= {1'b0, htot};
   assign frame_end = line_end && (line >= vtot);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         smp  <= '0;
         line <= FLD_W'(1);
      end else if (line_end) begin
         smp  <= '0;
         line <= frame_end ? FLD_W'(1) : line + 1'b1;
      end else begin
         smp  <= smp_inc[FLD_W-1:0];
      end
   end

   // R2: sample position stays inside the programmed line
   a_r2_sample_in_line: assert property (@(posedge clk) disable iff (rst)
      (htot != '0) |-> (smp < htot));
   // R2: inside a line the sample advances by one per clock
   a_r2_sample_steps: assert property (@(posedge clk) disable iff (rst)
      (!restart && !line_end) |=> (smp == $past(smp) + 1'b1));
   // R3: line numbers are 1-based and never pass the frame height
   a_r3_line_in_frame: assert property (@(posedge clk) disable iff (rst)
      (line != '0) && ((vtot == '0) || (line <= vtot)));
endmodule

// File: rtl/vsg_chan.sv
module vsg_chan
   import vsg_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  fld_t    smp,
   input  fld_t    line,
   input  ch_cfg_t cfg,
   output logic    hsync,
   output logic    vsync
);
   logic [REG_W-1:0] pos, rise, fall;

   assign pos  = {line, smp};
   assign rise = {cfg.vl_rise, cfg.vs_rise};
   assign fall = {cfg.vl_fall, cfg.vs_fall};

   // Half-open windows; a window whose end precedes its start wraps
   always_comb begin
      if (cfg.h_start <= cfg.h_stop)
         hsync = (smp >= cfg.h_start) && (smp < cfg.h_stop);
      else
         hsync = (smp >= cfg.h_start) || (smp < cfg.h_stop);

      if (rise <= fall)
         vsync = (pos >= rise) && (pos < fall);
      else
         vsync = (pos >= rise) || (pos < fall);
   end

   // R4: an empty horizontal window never pulses
   a_r4_empty_hsync: assert property (@(posedge clk) disable iff (rst)
      (cfg.h_start == cfg.h_stop) |-> !hsync);
   // R6: an empty vertical window never pulses
   a_r6_empty_vsync: assert property (@(posedge clk) disable iff (rst)
      (rise == fall) |-> !vsync);
endmodule

// File: rtl/video_sync_gen.sv
module video_sync_gen
   import vsg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              ext_sync,
   output logic [NUM_CH-1:0] hsync_o,
   output logic [NUM_CH-1:0] vsync_o
);
   localparam int ADDR_SPAN = (NUM_CH + 1) << CH_SHIFT;

   if (NUM_CH < 1 || ADDR_W <= CH_SHIFT || ADDR_SPAN > (1 << ADDR_W)) begin : g_bad_cfg
      $error("video_sync_gen: ADDR_W too small for NUM_CH channel groups");
   end

   logic                  slave_q, restart, frame_end, load;
   fld_t                  htot_q, vtot_q, smp, line;
   ch_cfg_t [NUM_CH-1:0]  cfg_q;

   assign restart = slave_q && ext_sync;
   assign load    = frame_end || restart;

   vsg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load(load), .slave_q(slave_q), .htot_q(htot_q), .vtot_q(vtot_q), .cfg_q(cfg_q)
   );

   vsg_counter u_cnt (
      .clk(clk), .rst(rst), .htot(htot_q), .vtot(vtot_q), .restart(restart),
      .smp(smp), .line(line), .frame_end(frame_end)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_out
      vsg_chan u_chan (
         .clk(clk), .rst(rst), .smp(smp), .line(line), .cfg(cfg_q[c]),
         .hsync(hsync_o[c]), .vsync(vsync_o[c])
      );
   end

   // R8: an external sync in slave mode restarts the frame
   a_r8_slave_restart: assert property (@(posedge clk) disable iff (rst)
      (slave_q && ext_sync) |=> (smp == '0 && line == FLD_W'(1)));
   // R3: the frame wraps to line 1 after its last line
   a_r3_frame_wrap: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (smp == '0 && line == FLD_W'(1)));
endmodule

// File: tb/video_sync_gen_bench.sv
module video_sync_gen_bench;
   localparam int NCH = 4;
   localparam int H   = 10;
   localparam int V   = 6;

   // hstart, hstop, rise line, rise sample, fall line, fall sample, hsync/line, vsync/frame
   localparam logic [15:0] TBL [0:7][0:7] = '{
      '{16'd0, 16'd3, 16'd1, 16'd0, 16'd3, 16'd0, 16'd3, 16'd20},
      '{16'd2, 16'd5, 16'd1, 16'd2, 16'd3, 16'd2, 16'd3, 16'd20},
      '{16'd8, 16'd1, 16'd6, 16'd8, 16'd2, 16'd8, 16'd3, 16'd20},
      '{16'd4, 16'd4, 16'd2, 16'd0, 16'd2, 16'd0, 16'd0, 16'd0},
      '{16'd0, 16'd9, 16'd2, 16'd5, 16'd5, 16'd5, 16'd9, 16'd30},
      '{16'd9, 16'd0, 16'd5, 16'd3, 16'd1, 16'd0, 16'd1, 16'd17},
      '{16'd1, 16'd2, 16'd1, 16'd0, 16'd6, 16'd9, 16'd1, 16'd59},
      '{16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}
   };

   logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, ext_sync = 1'b0;
   logic [5:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [NCH-1:0] hsync_o, vsync_o;

   video_sync_gen u_video_sync_gen (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ext_sync(ext_sync), .hsync_o(hsync_o), .vsync_o(vsync_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0;

   // Reference model built from the requirements
   logic [15:0] m_s, m_l, cur_h, cur_v, pend_h, pend_v;
   logic        cur_slave, pend_slave;
   logic [15:0] cur [NCH][6];
   logic [15:0] pend[NCH][6];

   always @(posedge clk) begin
      logic rs, wrp, fend;
      if (rst) begin
         m_s = 0; m_l = 1; cur_h = 0; cur_v = 0; pend_h = 0; pend_v = 0;
         cur_slave = 0; pend_slave = 0;
         for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 6; k++) begin cur[c][k] = 0; pend[c][k] = 0; end
      end else begin
         rs   = cur_slave && ext_sync;
         wrp  = (32'(m_s) + 1) >= 32'(cur_h);
         fend = wrp && (m_l >= cur_v);
         if (rs) begin m_s = 0; m_l = 1; end
         else if (wrp) begin m_s = 0; m_l = fend ? 16'd1 : m_l + 16'd1; end
         else m_s = m_s + 16'd1;
         if (rs || fend) begin
            cur_slave = pend_slave; cur_h = pend_h; cur_v = pend_v;
            for (int c = 0; c < NCH; c++)
               for (int k = 0; k < 6; k++) cur[c][k] = pend[c][k];
         end
         if (wr_en) begin
            if (wr_addr == 0) pend_slave = wr_data[0];
            else if (wr_addr == 1) pend_h = wr_data[15:0];
            else if (wr_addr == 2) pend_v = wr_data[15:0];
            else if (wr_addr[5:3] >= 1 && wr_addr[5:3] <= NCH) begin
               case (wr_addr[2:0])
                  3'd0: begin pend[wr_addr[5:3]-1][0] = wr_data[15:0]; pend[wr_addr[5:3]-1][1] = wr_data[31:16]; end
                  3'd1: begin pend[wr_addr[5:3]-1][2] = wr_data[15:0]; pend[wr_addr[5:3]-1][4] = wr_data[31:16]; end
                  3'd3: begin pend[wr_addr[5:3]-1][3] = wr_data[15:0]; pend[wr_addr[5:3]-1][5] = wr_data[31:16]; end
                  default: ;
               endcase
            end
         end
      end
   end

   function automatic logic win(input logic [31:0] p, input logic [31:0] a, input logic [31:0] b);
      return (a <= b) ? (p >= a && p < b) : (p >= a || p < b);
   endfunction

   int hi_h[NCH], hi_v[NCH];

   // Compare every channel each cycle for n cycles, then one check per channel
   task automatic sweep(input int n, input string tag);
      int bad[NCH];
      logic [1:0] act_b[NCH], exp_b[NCH];
      logic [15:0] bl[NCH], bs[NCH];
      for (int c = 0; c < NCH; c++) begin bad[c] = 0; hi_h[c] = 0; hi_v[c] = 0; end
      for (int i = 0; i < n; i++) begin
         for (int c = 0; c < NCH; c++) begin
            logic eh, ev;
            eh = win({16'd0, m_s}, {16'd0, cur[c][0]}, {16'd0, cur[c][1]});
            ev = win({m_l, m_s}, {cur[c][2], cur[c][3]}, {cur[c][4], cur[c][5]});
            hi_h[c] += int'(hsync_o[c]);
            hi_v[c] += int'(vsync_o[c]);
            if ({hsync_o[c], vsync_o[c]} !== {eh, ev}) begin
               if (bad[c] == 0) begin
                  act_b[c] = {hsync_o[c], vsync_o[c]}; exp_b[c] = {eh, ev};
                  bl[c] = m_l; bs[c] = m_s;
               end
               bad[c]++;
            end
         end
         @(negedge clk);
      end
      for (int c = 0; c < NCH; c++) begin
         n_chk++;
         if (bad[c] != 0) begin
            n_fail++;
            $display("FAIL %s ch%0d line %0d sample %0d: {hsync,vsync} actual=%b expected=%b (%0d bad cycles)",
                     tag, c, bl[c], bs[c], act_b[c], exp_b[c], bad[c]);
         end
      end
   endtask

   task automatic check_cnt(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_ext();
      ext_sync = 1'b1;
      @(negedge clk);
      ext_sync = 1'b0;
   endtask

   task automatic prog(input int ch, input int r);
      wr(8 * (ch + 1) + 0, {TBL[r][1], TBL[r][0]});
      wr(8 * (ch + 1) + 1, {TBL[r][4], TBL[r][2]});
      wr(8 * (ch + 1) + 3, {TBL[r][5], TBL[r][3]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs low while in reset
      check_cnt(int'(hsync_o) + int'(vsync_o), 0, "R1 outputs during reset");
      rst = 1'b0;
      sweep(5, "R1 after reset");

      wr(0, 32'd1);          // slave mode
      wr(1, H);
      wr(2, V);
      repeat (3) @(negedge clk);

      // Table walk: program one channel, align with a slave restart, check a frame
      for (int r = 0; r < 8; r++) begin
         prog(r % NCH, r);
         @(negedge clk);
         pulse_ext();
         sweep(H * V, "R2 R3 R4 R5 R6 table");
         check_cnt(hi_h[r % NCH], int'(TBL[r][6]) * V, "R4 R5 hsync cycles per frame");
         check_cnt(hi_v[r % NCH], int'(TBL[r][7]), "R6 vsync cycles per frame");
         sweep(H * V, "R2 R3 second frame");
      end

      // R8: restart in the middle of a frame
      pulse_ext();
      sweep(13, "R8 before restart");
      pulse_ext();
      check_cnt(int'(m_l) * 100 + int'(m_s), 100, "R8 model aligned");
      sweep(2 * H * V, "R8 after restart");

      // R7: a mid-frame write waits for the next frame start
      pulse_ext();
      sweep(25, "R7 before write");
      wr(8, {16'd7, 16'd6});
      wr(9, {16'd4, 16'd2});
      sweep(2 * H * V, "R7 deferred write");

      // R10: bottom-field and unmapped writes change nothing
      wr(8 * 2 + 2, 32'hFFFF_0003);
      wr(8 * 2 + 4, 32'h0005_0009);
      wr(3, 32'hFFFF_FFFF);
      wr(13, 32'h0000_0001);
      wr(48, 32'h0001_0002);
      sweep(2 * H * V, "R10 ignored writes");

      // R2 R3: new line length and frame height at the next frame start
      wr(1, 7);
      wr(2, 4);
      sweep(3 * H * V, "R2 R3 new totals");

      // R9: back to master, external sync must be ignored
      wr(0, 32'd0);
      sweep(2 * H * V, "R9 mode change");
      sweep(5, "R9 before ext");
      pulse_ext();
      sweep(2 * H * V, "R9 ext ignored");

      // R1: reset mid-run
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check_cnt(int'(hsync_o) + int'(vsync_o), 0, "R1 outputs in mid-run reset");
      rst = 1'b0;
      sweep(20, "R1 after mid-run reset");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule